// File: doc/BRIEF.md
# Vector Length State Register Unit

This unit holds the loop-control state of a parallel execution context in one packed 30-bit word: the maximum vector length, the current vector length, the sub-vector group size, and the element and sub-element offsets of the running loop. Software reaches it through a CSR-style port. A two-bit select chooses the maximum length, the current length or the whole packed word. A write strobe commits a new value, and an immediate flag marks writes whose operand is the wanted length minus one. The same port returns, in the same cycle, the value that the CSR instruction should put in its destination register.

Both lengths are kept biased by one, so a field value of 0 means length 1 and the full range up to XLEN fits in six bits. Every length write is clamped into range before it is stored. A loop sequencer moves the offset fields through a separate update port. A trap strobe exchanges the live word with a shadow word, so that a privilege transition in either direction saves one context and restores the other in a single cycle.

Top module: `vls_unit`

## Requirements
- R1: After reset the live word and the shadow word are both all zeros, so the maximum length, the current length and the group size all read as 1.
- R2: The packed word, from bit 0 up, holds: maximum length field in bits 5:0, current length field in 11:6, source offset in 17:12, destination offset in 23:18, group-size field in 25:24, source sub-offset in 27:26 and destination sub-offset in 29:28. A read with select 2 returns the stored word exactly, zero-extended, in the same cycle.
- R3: The length fields are biased by one. The length outputs equal the field plus one, and writing length n stores n-1.
- R4: A write with select 0 sets the maximum length to the requested value, with 0 raised to 1 and anything above XLEN lowered to XLEN. The read value in that cycle is the resulting length.
- R5: A write with select 1 sets the current length to the minimum of the clamped request (0 raised to 1, capped at XLEN) and the maximum length. The read value in that cycle is that resulting length.
- R6: When the immediate flag is set, one is added to the operand before clamping, with no wrap-around.
- R7: A maximum-length write below the current length lowers the current length to the new maximum. Otherwise the current length is kept.
- R8: A packed-word write (select 2) stores the offset, sub-offset and group-size fields as given. It caps the maximum length field at XLEN-1 and the current length field at the stored maximum length field.
- R9: The update port overwrites the four offset fields and nothing else. A packed-word write in the same cycle takes priority over it. With no update and no packed-word write, the offsets hold.
- R10: A trap strobe exchanges the live and shadow words at the next edge. Any write or update in that cycle is discarded.
- R11: Select 3 reads as 0, and a write with select 3 changes nothing.
- R12: The group-size field encodes sizes 1 to 4 as 0 to 3, and the group-size output equals the field plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Commit the selected write at this edge |
| wr_sel | input | 2 | 0 maximum length, 1 current length, 2 packed word, 3 unused |
| wr_imm | input | 1 | Operand is the length minus one |
| wr_data | input | DATA_W | Write operand |
| rd_data | output | DATA_W | Value for the destination register (combinational) |
| upd_en | input | 1 | Sequencer offset update |
| upd_src_offs | input | 6 | New source element offset |
| upd_dst_offs | input | 6 | New destination element offset |
| upd_src_sub | input | 2 | New source sub-element offset |
| upd_dst_sub | input | 2 | New destination sub-element offset |
| trap_swap | input | 1 | Exchange the live and shadow words |
| state_o | output | 30 | Live packed word |
| vl_len_o | output | LEN_W | Current length, unbiased |
| mvl_len_o | output | LEN_W | Maximum length, unbiased |
| subvl_len_o | output | 3 | Group size, 1 to 4 |

## Verification
`rd_data` is combinational. For a write it reflects the clamped result in the same cycle the write is presented, so the bench samples it one nanosecond after driving the inputs on the falling edge, before the rising edge that commits the write. The stored word, the length outputs and the effect of a swap or update appear after exactly one rising edge. The bench compares them with its model one nanosecond after that edge, once every cycle. The model advances only at that same edge, so each comparison sees the model and the design at the same point in time.

// File: rtl/vls_pkg.sv
package vls_pkg;
   localparam int FW      = 6;
   localparam int OFF_W   = 6;
   localparam int SUB_W   = 2;
   localparam int STATE_W = 2*FW + 2*OFF_W + 3*SUB_W;

   typedef struct packed {
      logic [SUB_W-1:0] dsv;
      logic [SUB_W-1:0] ssv;
      logic [SUB_W-1:0] subvl;
      logic [OFF_W-1:0] doff;
      logic [OFF_W-1:0] soff;
      logic [FW-1:0]    vl;
      logic [FW-1:0]    mvl;
   } vls_word_t;

   typedef enum logic [1:0] {
      SEL_MVL   = 2'd0,
      SEL_VL    = 2'd1,
      SEL_STATE = 2'd2,
      SEL_NONE  = 2'd3
   } vls_sel_e;
endpackage

// File: rtl/vls_len_clamp.sv
module vls_len_clamp #(
   parameter int XLEN   = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 6
) (
   input  logic [DATA_W-1:0] req,
   input  logic              is_imm,
   input  logic [LEN_W-1:0]  limit,
   output logic [LEN_W-1:0]  len
);
   localparam logic [DATA_W:0] XLEN_WIDE = (DATA_W+1)'(XLEN);

   logic [DATA_W:0]  full;
   logic [LEN_W-1:0] capped;

   always_comb begin
      // widened sum: an all-ones immediate cannot wrap to zero
      full = {1'b0, req} + {{DATA_W{1'b0}}, is_imm};
      if (full == '0)
         capped = LEN_W'(1);
      else if (full > XLEN_WIDE)
         capped = LEN_W'(XLEN);
      else
         capped = full[LEN_W-1:0];
      len = (capped > limit) ? limit : capped;
   end
endmodule

// File: rtl/vls_next.sv
module vls_next
   import vls_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 6
) (
   input  vls_word_t         cur,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic              wr_imm,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd_en,
   input  logic [OFF_W-1:0]  upd_src_offs,
   input  logic [OFF_W-1:0]  upd_dst_offs,
   input  logic [SUB_W-1:0]  upd_src_sub,
   input  logic [SUB_W-1:0]  upd_dst_sub,
   output vls_word_t         nxt,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [LEN_W-1:0] XLEN_LEN  = LEN_W'(XLEN);
   localparam logic [FW-1:0]    MVL_MAX_F = FW'(XLEN-1);

   logic [LEN_W-1:0] cur_mvl_len, cur_vl_len;
   logic [LEN_W-1:0] mvl_req_len, vl_req_len;
   vls_word_t        wr_word, san_word;
   logic             word_wr;

   function automatic logic [FW-1:0] len2field(input logic [LEN_W-1:0] l);
      return FW'(l - LEN_W'(1));
   endfunction

   assign cur_mvl_len = LEN_W'(cur.mvl) + LEN_W'(1);
   assign cur_vl_len  = LEN_W'(cur.vl)  + LEN_W'(1);
   assign wr_word     = vls_word_t'(wr_data[STATE_W-1:0]);
   assign word_wr     = wr_en && (vls_sel_e'(wr_sel) == SEL_STATE);

   vls_len_clamp #(.XLEN(XLEN), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_mvl_clamp (
      .req(wr_data), .is_imm(wr_imm), .limit(XLEN_LEN), .len(mvl_req_len)
   );

   vls_len_clamp #(.XLEN(XLEN), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_vl_clamp (
      .req(wr_data), .is_imm(wr_imm), .limit(cur_mvl_len), .len(vl_req_len)
   );

   always_comb begin
      san_word = wr_word;
      if (san_word.mvl > MVL_MAX_F) san_word.mvl = MVL_MAX_F;
      if (san_word.vl > san_word.mvl) san_word.vl = san_word.mvl;
   end

   always_comb begin
      nxt     = cur;
      rd_data = '0;
      case (vls_sel_e'(wr_sel))
         SEL_MVL: begin
            rd_data = DATA_W'(wr_en ? mvl_req_len : cur_mvl_len);
            if (wr_en) begin
               nxt.mvl = len2field(mvl_req_len);
               if (cur_vl_len > mvl_req_len) nxt.vl = len2field(mvl_req_len);
            end
         end
         SEL_VL: begin
            rd_data = DATA_W'(wr_en ? vl_req_len : cur_vl_len);
            if (wr_en) nxt.vl = len2field(vl_req_len);
         end
         SEL_STATE: begin
            rd_data = DATA_W'(cur);
            if (wr_en) nxt = san_word;
         end
         default: ;
      endcase
      if (upd_en && !word_wr) begin
         nxt.soff = upd_src_offs;
         nxt.doff = upd_dst_offs;
         nxt.ssv  = upd_src_sub;
         nxt.dsv  = upd_dst_sub;
      end
   end
endmodule

// File: rtl/vls_unit.sv
module vls_unit
   import vls_pkg::*;
#(
   parameter int   XLEN       = 32,
   parameter int   DATA_W     = 32,
   parameter bit   HAS_SHADOW = 1'b1,
   localparam int  LEN_W      = $clog2(XLEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic              wr_imm,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              upd_en,
   input  logic [5:0]        upd_src_offs,
   input  logic [5:0]        upd_dst_offs,
   input  logic [1:0]        upd_src_sub,
   input  logic [1:0]        upd_dst_sub,
   input  logic              trap_swap,
   output logic [29:0]       state_o,
   output logic [LEN_W-1:0]  vl_len_o,
   output logic [LEN_W-1:0]  mvl_len_o,
   output logic [2:0]        subvl_len_o
);
   initial begin
      assert (XLEN >= 1 && XLEN <= 64)
         else $fatal(1, "vls_unit: XLEN must be 1..64");
      assert (DATA_W >= STATE_W && DATA_W >= LEN_W)
         else $fatal(1, "vls_unit: DATA_W too narrow for the packed word");
   end

   vls_word_t live_q, shadow_q, nxt;
   logic      swap_do;

   vls_next #(.XLEN(XLEN), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_next (
      .cur(live_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_imm(wr_imm),
      .wr_data(wr_data), .upd_en(upd_en), .upd_src_offs(upd_src_offs),
      .upd_dst_offs(upd_dst_offs), .upd_src_sub(upd_src_sub),
      .upd_dst_sub(upd_dst_sub), .nxt(nxt), .rd_data(rd_data)
   );

   generate
      if (HAS_SHADOW) begin : g_shadow
         assign swap_do = trap_swap;
         always_ff @(posedge clk) begin
            if (!rst_n)       shadow_q <= '0;
            else if (swap_do) shadow_q <= live_q;
         end
         // R10
         swap_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trap_swap |=> (shadow_q == $past(live_q)));
      end else begin : g_no_shadow
         assign swap_do  = 1'b0;
         assign shadow_q = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       live_q <= '0;
      else if (swap_do) live_q <= shadow_q;
      else              live_q <= nxt;
   end

   assign state_o     = live_q;
   assign vl_len_o    = LEN_W'(live_q.vl)  + LEN_W'(1);
   assign mvl_len_o   = LEN_W'(live_q.mvl) + LEN_W'(1);
   assign subvl_len_o = {1'b0, live_q.subvl} + 3'd1;

   // R5
   vl_le_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q.vl <= live_q.mvl);
   // R4
   mvl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q.mvl <= FW'(XLEN-1));
   // R5
   vl_rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |-> (rd_data != '0 && rd_data <= DATA_W'(mvl_len_o)));
   // R10
   swap_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_SHADOW && trap_swap) |=> (live_q == $past(shadow_q)));
   // R9
   offs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !trap_swap && !(wr_en && wr_sel == 2'd2)) |=>
         ($stable(live_q.soff) && $stable(live_q.doff) &&
          $stable(live_q.ssv) && $stable(live_q.dsv)));
endmodule

// File: tb/vls_unit_tb.sv
`timescale 1ns/1ps
module vls_unit_tb;
   localparam int XL = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_imm = 1'b0, upd_en = 1'b0, trap_swap = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic [31:0] wr_data = '0;
   logic [5:0]  upd_src_offs = '0, upd_dst_offs = '0;
   logic [1:0]  upd_src_sub = '0, upd_dst_sub = '0;
   logic [31:0] rd_data;
   logic [29:0] state_o;
   logic [5:0]  vl_len_o, mvl_len_o;
   logic [2:0]  subvl_len_o;

   int errors = 0, checks = 0;
   bit done = 0;

   // behavioural model: lengths unbiased, offsets raw
   int m_mvl = 1, m_vl = 1, m_soff = 0, m_doff = 0, m_sub = 0, m_ssv = 0, m_dsv = 0;
   logic [29:0] m_sh = '0;

   always #10 clk = ~clk;

   vls_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_imm(wr_imm),
      .wr_data(wr_data), .rd_data(rd_data), .upd_en(upd_en),
      .upd_src_offs(upd_src_offs), .upd_dst_offs(upd_dst_offs),
      .upd_src_sub(upd_src_sub), .upd_dst_sub(upd_dst_sub),
      .trap_swap(trap_swap), .state_o(state_o), .vl_len_o(vl_len_o),
      .mvl_len_o(mvl_len_o), .subvl_len_o(subvl_len_o)
   );

   function automatic logic [29:0] mpack();
      return {m_dsv[1:0], m_ssv[1:0], m_sub[1:0], m_doff[5:0], m_soff[5:0],
              6'(m_vl - 1), 6'(m_mvl - 1)};
   endfunction

   function automatic int clampl(longint req, bit imm, int lim);
      longint f = req + longint'(imm);
      if (f == 0) f = 1;
      if (f > XL) f = XL;
      if (f > lim) f = lim;
      return int'(f);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_outs(string tag);
      checks++;
      if (state_o !== mpack() || vl_len_o !== 6'(m_vl) || mvl_len_o !== 6'(m_mvl)
          || subvl_len_o !== 3'(m_sub + 1)) begin
         errors++;
         $display("FAIL %s: actual state=%h vl=%0d mvl=%0d sub=%0d expected state=%h vl=%0d mvl=%0d sub=%0d",
                  tag, state_o, vl_len_o, mvl_len_o, subvl_len_o,
                  mpack(), m_vl, m_mvl, m_sub + 1);
      end
   endtask

   task automatic step(string tag, bit we, logic [1:0] sel, logic [31:0] d, bit imm,
                       bit ue, logic [5:0] us, logic [5:0] ud, logic [1:0] uss,
                       logic [1:0] uds, bit tr);
      int n_mvl, n_vl, n_soff, n_doff, n_sub, n_ssv, n_dsv, fm, fv;
      logic [31:0] exp_rd;
      logic [29:0] old;
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d; wr_imm = imm; upd_en = ue;
      upd_src_offs = us; upd_dst_offs = ud; upd_src_sub = uss; upd_dst_sub = uds;
      trap_swap = tr;
      #1;
      n_mvl = m_mvl; n_vl = m_vl; n_soff = m_soff; n_doff = m_doff;
      n_sub = m_sub; n_ssv = m_ssv; n_dsv = m_dsv;
      exp_rd = '0;
      case (sel)
         2'd0: begin
            exp_rd = we ? clampl(d, imm, XL) : m_mvl;
            if (we) begin n_mvl = exp_rd; if (m_vl > n_mvl) n_vl = n_mvl; end
         end
         2'd1: begin
            exp_rd = we ? clampl(d, imm, m_mvl) : m_vl;
            if (we) n_vl = exp_rd;
         end
         2'd2: begin
            exp_rd = {2'b0, mpack()};
            if (we) begin
               fm = d[5:0]; if (fm > XL - 1) fm = XL - 1;
               fv = d[11:6]; if (fv > fm) fv = fm;
               n_mvl = fm + 1; n_vl = fv + 1;
               n_soff = d[17:12]; n_doff = d[23:18]; n_sub = d[25:24];
               n_ssv = d[27:26]; n_dsv = d[29:28];
            end
         end
         default: exp_rd = '0;
      endcase
      if (ue && !(we && sel == 2'd2)) begin
         n_soff = us; n_doff = ud; n_ssv = uss; n_dsv = uds;
      end
      chk({tag, " rd"}, rd_data, exp_rd);
      @(posedge clk);
      if (tr) begin
         old = mpack();
         m_mvl = m_sh[5:0] + 1; m_vl = m_sh[11:6] + 1; m_soff = m_sh[17:12];
         m_doff = m_sh[23:18]; m_sub = m_sh[25:24]; m_ssv = m_sh[27:26];
         m_dsv = m_sh[29:28]; m_sh = old;
      end else begin
         m_mvl = n_mvl; m_vl = n_vl; m_soff = n_soff; m_doff = n_doff;
         m_sub = n_sub; m_ssv = n_ssv; m_dsv = n_dsv;
      end
      #1;
      check_outs({tag, " state"});
   endtask

   task automatic wr(string tag, logic [1:0] sel, logic [31:0] d, bit imm = 0);
      step(tag, 1, sel, d, imm, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check_outs("R1 reset live");
      // R1: shadow comes back as zeros on first swap
      step("R1 R10 shadow reset", 0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 1);
      step("R1 R10 swap back", 0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 1);
      wr("R4 R3 mvl 8", 2'd0, 32'd8);
      wr("R5 vl 5", 2'd1, 32'd5);
      wr("R5 vl above mvl", 2'd1, 32'd20);
      wr("R5 vl zero", 2'd1, 32'd0);
      wr("R6 vl imm 3", 2'd1, 32'd3, 1);
      wr("R4 mvl above xlen", 2'd0, 32'd100);
      wr("R6 mvl imm 31", 2'd0, 32'd31, 1);
      wr("R5 R6 vl imm all ones", 2'd1, 32'hFFFF_FFFF, 1);
      wr("R4 mvl zero", 2'd0, 32'd0);
      wr("R4 mvl 16", 2'd0, 32'd16);
      wr("R5 vl 12", 2'd1, 32'd12);
      wr("R7 mvl below vl", 2'd0, 32'd6);
      wr("R7 mvl above vl", 2'd0, 32'd10);
      wr("R2 R8 R12 word write", 2'd2, {2'b0, 2'd3, 2'd1, 2'd2, 6'd45, 6'd17, 6'd9, 6'd20});
      step("R2 word read", 0, 2'd2, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0);
      wr("R8 word caps mvl", 2'd2, {2'b0, 2'd0, 2'd0, 2'd3, 6'd1, 6'd2, 6'd50, 6'd63});
      wr("R8 word caps vl", 2'd2, {2'b0, 2'd2, 2'd3, 2'd0, 6'd0, 6'd63, 6'd40, 6'd10});
      step("R9 update", 0, 2'd3, 0, 0, 1, 6'd33, 6'd7, 2'd2, 2'd1, 0);
      step("R9 update loses to word", 1, 2'd2, {2'b0, 2'd1, 2'd1, 2'd1, 6'd5, 6'd4, 6'd3, 6'd8},
           0, 1, 6'd60, 6'd61, 2'd3, 2'd3, 0);
      step("R9 update with vl write", 1, 2'd1, 32'd2, 0, 1, 6'd11, 6'd22, 2'd0, 2'd3, 0);
      step("R10 swap", 0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 1);
      step("R10 swap drops write", 1, 2'd0, 32'd3, 0, 1, 6'd9, 6'd9, 2'd1, 2'd1, 1);
      wr("R11 sel3 write", 2'd3, 32'hFFFF_FFFF);
      step("R11 sel3 read", 0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R3 mvl read", 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R3 vl read", 0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 300; i++) begin
         logic [31:0] d = $urandom;
         if ($urandom_range(0, 1) == 0) d = 32'($urandom_range(0, 40));
         step("R12 R9 R5 random", ($urandom_range(0, 2) != 0), 2'($urandom_range(0, 3)), d,
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 6'($urandom),
              6'($urandom), 2'($urandom), 2'($urandom), ($urandom_range(0, 9) == 0));
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule